// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and decides when a small processor core should enter a handler and where it should jump. Every source owns a sticky pending flag, an individual enable and a priority bit. A mode input selects between two schemes. In the first scheme a single global enable masks every source. In the second scheme one enable masks high-priority sources and another masks low-priority sources, so that a high-priority service can nest inside a low-priority one.

When a request wins, the controller issues a one-cycle entry strobe together with the handler address and the index of the winning source. It then clears the enable of the level it entered. The core answers with a return strobe when a handler finishes. That strobe closes the innermost service and restores its enable. A two-entry in-service record keeps track of which levels are active. Software-style set and clear inputs for the flags and the enables are plain ports.

Top module: `irqPrioCtl`

## Requirements
- R1: Each flag is set by a one-cycle pulse on its bit of `flagSet` and stays set until a pulse on its bit of `flagClr`. When both arrive in the same cycle, the flag ends up set.
- R2: A source is eligible only when its flag, its bit of `srcEn` and its level enable are all 1. With `prioMode`=0, `enHi` gates every source. With `prioMode`=1, `enHi` gates sources whose `srcHigh` bit is 1, and `enLo` gates sources whose `srcHigh` bit is 0.
- R3: An eligible request seen before a clock edge produces `vecValid`=1 for exactly one cycle after that edge. `vecAddr` and `srcId` are valid in the same cycle.
- R4: High-priority entry reports `vecAddr`=0x0008 and low-priority entry reports 0x0018. With `prioMode`=0 every entry reports 0x0008.
- R5: When both levels have eligible requests, the high level wins. Within the winning level, `srcId` is the lowest eligible index.
- R6: On entry, the enable of the level entered is cleared in the same cycle that `vecValid` rises, and the matching in-service bit is set. A single-level entry or a high entry clears `enHi` and sets `inSvcHi`. A low entry clears `enLo` and sets `inSvcLo`.
- R7: A high-priority request is accepted while a low-priority service is in progress, leaving both in-service bits set.
- R8: No low-priority entry occurs while `inSvcHi` is 1.
- R9: A `retStrobe` pulse behaves as follows:
  - It ends the high service first if one is active. It clears `inSvcHi` and sets `enHi`, and leaves `inSvcLo` unchanged.
  - Otherwise it clears `inSvcLo` and sets `enLo`.
  - With nothing in service it changes no enable.
  - No entry is taken in the cycle of the strobe.
- R10: A flag left set when its handler returns causes a new entry for the same source once the enable is restored.
- R11: A synchronous active-high `rst` clears all flags, both enables, both in-service bits and `vecValid`.
- R12: For `swEnSet` and `swEnClr`, bit 0 addresses `enHi` and bit 1 addresses `enLo`. A clear pulse drops the enable and a set pulse raises it; set wins over clear. The effects of entry and return override both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prioMode | input | 1 | 0: single global enable; 1: two-level nesting |
| flagSet | input | NUM_SRC | Per-source flag set pulses from peripherals |
| flagClr | input | NUM_SRC | Per-source flag clear pulses from software |
| srcEn | input | NUM_SRC | Per-source enables |
| srcHigh | input | NUM_SRC | Per-source priority bit, 1 = high |
| swEnSet | input | 2 | Set pulses for enHi (bit 0) and enLo (bit 1) |
| swEnClr | input | 2 | Clear pulses for enHi (bit 0) and enLo (bit 1) |
| retStrobe | input | 1 | Return-from-interrupt strobe from the core |
| flags | output | NUM_SRC | Sticky pending flags |
| enHi | output | 1 | Global enable (single-level) or high-level enable |
| enLo | output | 1 | Low-level enable |
| inSvcHi | output | 1 | High (or single-level) service in progress |
| inSvcLo | output | 1 | Low service in progress |
| vecValid | output | 1 | One-cycle entry strobe (push return address, load vector) |
| vecAddr | output | VEC_W | Handler vector for the entry |
| srcId | output | $clog2(NUM_SRC) | Lowest-index winning source |

## Verification
The hardest state to reach is a nested service in which both levels are active. A return must then close only the high level, and a low request left pending while the high level runs must stay blocked until that return. The bench reaches this state by directed sequences. A low flag is raised first and its entry taken, then a high flag preempts it. In the blocking case, a low flag is raised while a high service is open and held there for several cycles. Arbitration itself is swept over every flag pattern against every priority assignment, in both modes, from a clean reset each time.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  // Enable control bit positions on the software enable ports
  localparam int EN_HI_BIT = 0;
  localparam int EN_LO_BIT = 1;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic takeHi;
    logic takeLo;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqFlagPath.sv
module irqFlagPath
  import irqPrioPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDW = 3,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 'h0018
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prioMode,
  input  logic [NUM_SRC-1:0] flagSet,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  ctrlStrobes_t       strb,
  output logic [NUM_SRC-1:0] flags,
  output logic               hiAny,
  output logic               loAny,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [IDW-1:0]     srcId
);
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] hiLvl;
  logic [NUM_SRC-1:0] loLvl;

  // Sticky flags: a set pulse beats a clear pulse
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (rst)             flagQ[g] <= 1'b0;
      else if (flagSet[g]) flagQ[g] <= 1'b1;
      else if (flagClr[g]) flagQ[g] <= 1'b0;
    end
  end

  // Level grouping: single-level mode puts every source in the high group
  assign hiLvl = flagQ & srcEn & (prioMode ? srcHigh : {NUM_SRC{1'b1}});
  assign loLvl = flagQ & srcEn & (prioMode ? ~srcHigh : {NUM_SRC{1'b0}});
  assign hiAny = |hiLvl;
  assign loAny = |loLvl;
  assign flags = flagQ;

  function automatic logic [IDW-1:0] lowIdx(input logic [NUM_SRC-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDW'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vecValid <= 1'b0;
      vecAddr  <= '0;
      srcId    <= '0;
    end else begin
      vecValid <= strb.takeHi | strb.takeLo;
      if (strb.takeHi) begin
        vecAddr <= HI_VEC;
        srcId   <= lowIdx(hiLvl);
      end else if (strb.takeLo) begin
        vecAddr <= LO_VEC;
        srcId   <= lowIdx(loLvl);
      end
    end
  end
endmodule

// File: rtl/irqSeqCtl.sv
module irqSeqCtl
  import irqPrioPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         prioMode,
  input  logic         hiAny,
  input  logic         loAny,
  input  logic         retStrobe,
  input  logic [1:0]   swEnSet,
  input  logic [1:0]   swEnClr,
  output logic         enHi,
  output logic         enLo,
  output logic         inSvcHi,
  output logic         inSvcLo,
  output ctrlStrobes_t strb
);
  logic retHi, retLo;
  logic enHiNext, enLoNext, svcHiNext, svcLoNext;

  // Arbitration: high beats low; low waits while a high service is open
  always_comb begin
    strb.takeHi = !retStrobe && hiAny && enHi;
    strb.takeLo = prioMode && !retStrobe && !strb.takeHi && loAny && enLo && !inSvcHi;
  end

  // Return closes the innermost active level
  assign retHi = retStrobe && inSvcHi;
  assign retLo = retStrobe && !inSvcHi && inSvcLo;

  always_comb begin
    enHiNext  = (enHi & ~swEnClr[EN_HI_BIT]) | swEnSet[EN_HI_BIT];
    enLoNext  = (enLo & ~swEnClr[EN_LO_BIT]) | swEnSet[EN_LO_BIT];
    svcHiNext = inSvcHi;
    svcLoNext = inSvcLo;
    if (strb.takeHi) begin
      enHiNext  = 1'b0;
      svcHiNext = 1'b1;
    end
    if (strb.takeLo) begin
      enLoNext  = 1'b0;
      svcLoNext = 1'b1;
    end
    if (retHi) begin
      enHiNext  = 1'b1;
      svcHiNext = 1'b0;
    end
    if (retLo) begin
      enLoNext  = 1'b1;
      svcLoNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enHi    <= 1'b0;
      enLo    <= 1'b0;
      inSvcHi <= 1'b0;
      inSvcLo <= 1'b0;
    end else begin
      enHi    <= enHiNext;
      enLo    <= enLoNext;
      inSvcHi <= svcHiNext;
      inSvcLo <= svcLoNext;
    end
  end
endmodule

// File: rtl/irqPrioCtl.sv
module irqPrioCtl
  import irqPrioPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 'h0018,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prioMode,
  input  logic [NUM_SRC-1:0] flagSet,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcHigh,
  input  logic [1:0]         swEnSet,
  input  logic [1:0]         swEnClr,
  input  logic               retStrobe,
  output logic [NUM_SRC-1:0] flags,
  output logic               enHi,
  output logic               enLo,
  output logic               inSvcHi,
  output logic               inSvcLo,
  output logic               vecValid,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [IDW-1:0]     srcId
);
  ctrlStrobes_t strb;
  logic hiAny, loAny;

  irqFlagPath #(
    .NUM_SRC(NUM_SRC), .IDW(IDW), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
  ) uPath (
    .clk(clk), .rst(rst), .prioMode(prioMode), .flagSet(flagSet), .flagClr(flagClr),
    .srcEn(srcEn), .srcHigh(srcHigh), .strb(strb), .flags(flags), .hiAny(hiAny),
    .loAny(loAny), .vecValid(vecValid), .vecAddr(vecAddr), .srcId(srcId)
  );

  irqSeqCtl uCtl (
    .clk(clk), .rst(rst), .prioMode(prioMode), .hiAny(hiAny), .loAny(loAny),
    .retStrobe(retStrobe), .swEnSet(swEnSet), .swEnClr(swEnClr), .enHi(enHi),
    .enLo(enLo), .inSvcHi(inSvcHi), .inSvcLo(inSvcLo), .strb(strb)
  );
endmodule

// File: rtl/irqPrioCtl_chk.sv
module irqPrioCtl_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 'h0018
) (
  input logic               clk,
  input logic               rst,
  input logic               prioMode,
  input logic [NUM_SRC-1:0] flagSet,
  input logic [NUM_SRC-1:0] flagClr,
  input logic [NUM_SRC-1:0] flags,
  input logic               retStrobe,
  input logic               enHi,
  input logic               enLo,
  input logic               inSvcHi,
  input logic               inSvcLo,
  input logic               vecValid,
  input logic [VEC_W-1:0]   vecAddr
);
  // R1: set pulse leaves the flag set, even with a clear in the same cycle
  p_set_wins_r1: assert property (@(posedge clk) disable iff (rst)
    (flagSet != '0) |=> ((flags & $past(flagSet)) == $past(flagSet)));

  // R1: a set flag without a clear stays set
  p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~flagClr) != '0) |=> ((flags & $past(flags & ~flagClr)) == $past(flags & ~flagClr)));

  // R3: entry strobe lasts one cycle
  p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    vecValid |=> !vecValid);

  // R4: single-level mode only ever reports the high vector
  p_single_vec_r4: assert property (@(posedge clk) disable iff (rst)
    (vecValid && !$past(prioMode)) |-> (vecAddr == HI_VEC));

  // R6: a high entry has closed the high enable
  p_entry_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (vecValid && vecAddr == HI_VEC) |-> (!enHi && inSvcHi));

  // R6: a low entry has closed the low enable
  p_entry_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (vecValid && vecAddr == LO_VEC) |-> (!enLo && inSvcLo));

  // R8: no low entry out of an open high service
  p_lo_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    (vecValid && vecAddr == LO_VEC) |-> !$past(inSvcHi));

  // R9: return from high restores its enable
  p_ret_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (retStrobe && inSvcHi) |=> (enHi && !inSvcHi));

  // R9: return from low restores its enable
  p_ret_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (retStrobe && !inSvcHi && inSvcLo) |=> (enLo && !inSvcLo));

  // R7: leaving a preempting high service keeps the low service open
  p_nest_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (retStrobe && inSvcHi && inSvcLo) |=> inSvcLo);
endmodule

bind irqPrioCtl irqPrioCtl_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
) uChk (
  .clk(clk), .rst(rst), .prioMode(prioMode), .flagSet(flagSet), .flagClr(flagClr),
  .flags(flags), .retStrobe(retStrobe), .enHi(enHi), .enLo(enLo), .inSvcHi(inSvcHi),
  .inSvcLo(inSvcLo), .vecValid(vecValid), .vecAddr(vecAddr)
);

// File: tb/tb_irqPrioCtl.sv
`timescale 1ns/1ps
module tb_irqPrioCtl;
  localparam int N = 4;
  localparam int IDW = 2;
  localparam int HIV = 'h0008;
  localparam int LOV = 'h0018;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prioMode = 1'b0;
  logic [N-1:0] flagSet = '0, flagClr = '0, srcEn = '0, srcHigh = '0;
  logic [1:0] swEnSet = '0, swEnClr = '0;
  logic retStrobe = 1'b0;
  logic [N-1:0] flags;
  logic enHi, enLo, inSvcHi, inSvcLo, vecValid;
  logic [15:0] vecAddr;
  logic [IDW-1:0] srcId;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqPrioCtl #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .prioMode(prioMode), .flagSet(flagSet), .flagClr(flagClr),
    .srcEn(srcEn), .srcHigh(srcHigh), .swEnSet(swEnSet), .swEnClr(swEnClr),
    .retStrobe(retStrobe), .flags(flags), .enHi(enHi), .enLo(enLo), .inSvcHi(inSvcHi),
    .inSvcLo(inSvcLo), .vecValid(vecValid), .vecAddr(vecAddr), .srcId(srcId)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    flagSet = '0; flagClr = '0; swEnSet = '0; swEnClr = '0; retStrobe = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    clearIn();
    tick();
    tick();
    rst = 1'b0;
  endtask

  function automatic int lowestBit(input int v);
    for (int i = 0; i < N; i++) if ((v >> i) % 2 == 1) return i;
    return 0;
  endfunction

  task automatic pulseRet();
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R11 reset state
    chk("R11", "flags", int'(flags), 0);
    chk("R11", "enables", int'({enHi, enLo}), 0);
    chk("R11", "inService", int'({inSvcHi, inSvcLo}), 0);
    chk("R11", "vecValid", int'(vecValid), 0);

    // R9: return with nothing in service changes nothing
    pulseRet();
    chk("R9", "idle return enables", int'({enHi, enLo}), 0);

    // R1: set beats clear, then clear alone works
    flagSet = 4'b0001; flagClr = 4'b0001; tick(); clearIn();
    chk("R1", "set wins", int'(flags), 1);
    tick();
    chk("R1", "flag sticky", int'(flags), 1);
    flagClr = 4'b0001; tick(); clearIn();
    chk("R1", "cleared", int'(flags), 0);

    // R12: software enable pulses
    swEnSet = 2'b11; tick(); clearIn();
    chk("R12", "both set", int'({enHi, enLo}), 3);
    swEnClr = 2'b01; tick(); clearIn();
    chk("R12", "enHi cleared", int'({enHi, enLo}), 1);
    swEnClr = 2'b10; swEnSet = 2'b10; tick(); clearIn();
    chk("R12", "set beats clear", int'(enLo), 1);

    // R3/R4/R5/R6 exhaustive sweep over both modes, masks, patterns
    for (int m = 0; m < 2; m++) begin
      for (int mask = 0; mask < 16; mask++) begin
        for (int pat = 0; pat < 16; pat++) begin
          int hiSet, loSet, expAddr, expId;
          bit expHi;
          doReset();
          prioMode = m[0]; srcHigh = mask[N-1:0]; srcEn = '1;
          swEnSet = 2'b11; flagSet = pat[N-1:0];
          tick();
          clearIn();
          tick();
          hiSet = (m == 1) ? (pat & mask) : pat;
          loSet = (m == 1) ? (pat & ~mask & 15) : 0;
          chk("R3", "vecValid after request", int'(vecValid), (pat != 0) ? 1 : 0);
          if (pat != 0) begin
            expHi = (hiSet != 0);
            expAddr = expHi ? HIV : LOV;
            expId = expHi ? lowestBit(hiSet) : lowestBit(loSet);
            chk("R4", "vector", int'(vecAddr), expAddr);
            chk("R5", "source index", int'(srcId), expId);
            if (expHi) chk("R6", "enHi cleared on entry", int'({enHi, inSvcHi}), 1);
            else       chk("R6", "enLo cleared on entry", int'({enLo, inSvcLo}), 1);
          end
        end
      end
    end

    // R2: individual enable and level enable gating
    doReset();
    prioMode = 1'b0; srcEn = 4'b0111; swEnSet = 2'b01; flagSet = 4'b1000;
    tick(); clearIn();
    begin
      int seen = 0;
      repeat (4) begin tick(); seen += int'(vecValid); end
      chk("R2", "source enable gates", seen, 0);
    end
    doReset();
    prioMode = 1'b1; srcHigh = 4'b1111; srcEn = '1; swEnSet = 2'b10; flagSet = 4'b0010;
    tick(); clearIn();
    begin
      int seen = 0;
      repeat (4) begin tick(); seen += int'(vecValid); end
      chk("R2", "high enable gates high source", seen, 0);
    end

    // R7/R9: low service preempted by high, then unwound
    doReset();
    prioMode = 1'b1; srcHigh = 4'b0010; srcEn = '1; swEnSet = 2'b11; flagSet = 4'b0001;
    tick(); clearIn(); tick();
    chk("R4", "low entry vector", int'(vecAddr), LOV);
    flagClr = 4'b0001; tick(); clearIn();
    flagSet = 4'b0010; tick(); clearIn(); tick();
    chk("R7", "preempt entry valid", int'(vecValid), 1);
    chk("R7", "preempt vector", int'(vecAddr), HIV);
    chk("R7", "both in service", int'({inSvcHi, inSvcLo}), 3);
    flagClr = 4'b0010; tick(); clearIn();
    pulseRet();
    chk("R9", "high exit leaves low", int'({inSvcHi, inSvcLo}), 1);
    chk("R9", "high exit enables", int'({enHi, enLo}), 2);
    pulseRet();
    chk("R9", "low exit", int'({inSvcHi, inSvcLo, enLo}), 1);

    // R8: low request blocked during high service
    doReset();
    prioMode = 1'b1; srcHigh = 4'b0010; srcEn = '1; swEnSet = 2'b11; flagSet = 4'b0010;
    tick(); clearIn(); tick();
    chk("R8", "high entry", int'(vecAddr), HIV);
    flagClr = 4'b0010; flagSet = 4'b0001; tick(); clearIn();
    begin
      int seen = 0;
      repeat (5) begin tick(); seen += int'(vecValid); end
      chk("R8", "low blocked while high served", seen, 0);
    end
    pulseRet();
    chk("R9", "no entry in return cycle", int'(vecValid), 0);
    tick();
    chk("R8", "low taken after high return", int'(vecValid), 1);
    chk("R8", "low vector", int'(vecAddr), LOV);

    // R10 and R3 pulse: flag left set is retaken after return
    doReset();
    prioMode = 1'b0; srcEn = '1; swEnSet = 2'b01; flagSet = 4'b0100;
    tick(); clearIn(); tick();
    chk("R3", "entry", int'(vecValid), 1);
    tick();
    chk("R3", "single cycle strobe", int'(vecValid), 0);
    pulseRet();
    tick();
    chk("R10", "retaken valid", int'(vecValid), 1);
    chk("R10", "retaken source", int'(srcId), 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule